// File: doc/BRIEF.md
# Mode-Switched Three-Bit Sequence Counter

This block is a three-bit synchronous counter whose output walks one of two fixed orderings of all eight codes. A single mode pin picks the ordering. With the pin high, the counter takes the even codes in rising order and then the odd codes in rising order. With the pin low, it follows a mixed ordering that visits each code once before it returns to zero.

The mode pin may change on any cycle. At each rising clock edge the counter looks up its present value in the ordering that the mode pin selects at that edge, and loads the code that follows it. No restart or realignment takes place. Every code appears in both orderings, so there is no unused code and no recovery logic is needed. A synchronous active-high reset puts the counter at zero.

Top module: `seq_mode_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `q` becomes 3'b000 after that edge, whatever the value of `mode`.
- R2: With `mode`=1 at every edge, `q` steps 0,2,4,6,1,3,5,7 and then returns to 0. Every even code below 6 advances by two.
- R3: With `mode`=0 at every edge, `q` steps 0,1,6,7,2,3,4,5 and then returns to 0.
- R4: The next value is always the successor of the present `q` in the ordering chosen by `mode` at that edge, and `mode` may change on any cycle.
- R5: The new `q[2]` equals (!m & !q0 & q2) | (m & q1 & !q2) | (!m & q0 & !q2) | (m & !q1 & q2), where m and q are the values at the edge.
- R6: The new `q[0]` equals (!m & !q0) | (!q0 & q1 & q2) | (m & q0 & !q2) | (m & q0 & !q1), where m and q are the values at the edge.
- R7: Outside reset, `q` changes at every edge. Eight steps in one mode bring it back to its starting value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| rst  | input  | 1 | Synchronous active-high reset to zero |
| mode | input  | 1 | Ordering select: 1 = evens then odds, 0 = mixed ordering |
| q    | output | 3 | Present counter value |

## Verification
The assertions check on every cycle that reset lands on zero, that the two bit equations hold between the previous state and mode and the new state, that the counter never stays on one value, and that a few fixed steps inside each ordering are taken. Only the bench scenarios can show that each ordering closes after exactly eight steps, that all sixteen pairs of value and mode give the right successor, and that switching mode on every cycle continues from the present value.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned NUM_CODES = 1 << CODE_W;
  localparam int unsigned NUM_KINDS = 2;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic {
    KIND_MIXED  = 1'b0,
    KIND_STRIDE = 1'b1
  } kind_e;

  // evens ascending, then odds ascending, then back to zero
  function automatic code_t stride_next(code_t cur);
    code_t r;
    if (cur == code_t'(NUM_CODES - 1))      r = '0;
    else if (cur == code_t'(NUM_CODES - 2)) r = code_t'(1);
    else                                    r = cur + code_t'(2);
    return r;
  endfunction

  // 0 1 6 7 2 3 4 5 loop
  function automatic code_t mixed_next(code_t cur);
    code_t r;
    case (cur)
      3'd0:    r = 3'd1;
      3'd1:    r = 3'd6;
      3'd6:    r = 3'd7;
      3'd7:    r = 3'd2;
      3'd2:    r = 3'd3;
      3'd3:    r = 3'd4;
      3'd4:    r = 3'd5;
      default: r = 3'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seqctr_succ.sv
module seqctr_succ
  import seqctr_pkg::*;
#(
  parameter kind_e KIND = KIND_MIXED
) (
  input  code_t cur,
  output code_t nxt
);
  generate
    if (KIND == KIND_STRIDE) begin : g_stride
      assign nxt = stride_next(cur);
    end else begin : g_mixed
      assign nxt = mixed_next(cur);
    end
  endgenerate
endmodule

// File: rtl/seqctr_sel.sv
module seqctr_sel
  import seqctr_pkg::*;
(
  input  logic                 sel,
  input  code_t [NUM_KINDS-1:0] cand,
  output code_t                 pick
);
  assign pick = cand[sel];
endmodule

// File: rtl/seqctr_reg.sv
module seqctr_reg
  import seqctr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  code_t d,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/seq_mode_counter.sv
module seq_mode_counter
  import seqctr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode,
  output logic [CODE_W-1:0]    q
);
  code_t [NUM_KINDS-1:0] cand;
  code_t                 nxt;
  code_t                 cur;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    seqctr_succ #(.KIND(kind_e'(k))) u_succ (
      .cur (cur),
      .nxt (cand[k])
    );
  end

  seqctr_sel u_sel (
    .sel  (mode),
    .cand (cand),
    .pick (nxt)
  );

  seqctr_reg u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt),
    .q   (cur)
  );

  assign q = cur;

  // reset lands on zero (R1)
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (q == '0));

  // even codes below six step by two in the stride ordering (R2)
  assert_stride_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mode && !q[0] && q != 3'd6) |=> (q == code_t'($past(q) + 3'd2)));

  // mixed ordering closes from five back to zero (R3)
  assert_mixed_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode && q == 3'd5) |=> (q == 3'd0));

  // bit two follows its sum of products (R5)
  assert_bit2_eqn_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[2] == ((!$past(mode) && !$past(q[0]) &&  $past(q[2])) ||
                       ( $past(mode) &&  $past(q[1]) && !$past(q[2])) ||
                       (!$past(mode) &&  $past(q[0]) && !$past(q[2])) ||
                       ( $past(mode) && !$past(q[1]) &&  $past(q[2])))));

  // bit zero follows its sum of products (R6)
  assert_bit0_eqn_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[0] == ((!$past(mode) && !$past(q[0])) ||
                       (!$past(q[0]) &&  $past(q[1]) && $past(q[2])) ||
                       ( $past(mode) &&  $past(q[0]) && !$past(q[2])) ||
                       ( $past(mode) &&  $past(q[0]) && !$past(q[1])))));

  // never parks on one code (R7)
  assert_always_moves_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q != $past(q)));
endmodule

// File: tb/tb_seq_mode_counter.sv
module tb_seq_mode_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [2:0] q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [2:0] expq[$];
  string      tagq[$];
  logic [2:0] mdl = 3'd0;

  int ord1[8] = '{0, 2, 4, 6, 1, 3, 5, 7};
  int ord0[8] = '{0, 1, 6, 7, 2, 3, 4, 5};

  always #4 clk = ~clk;

  seq_mode_counter dut (.clk(clk), .rst(rst), .mode(mode), .q(q));

  function automatic logic [2:0] ref_next(logic [2:0] v, logic m);
    int pos = 0;
    for (int i = 0; i < 8; i++) begin
      if ((m ? ord1[i] : ord0[i]) == int'(v)) pos = i;
    end
    return m ? 3'(ord1[(pos + 1) % 8]) : 3'(ord0[(pos + 1) % 8]);
  endfunction

  task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: q=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // driver: sets inputs for one edge and queues the expected value
  task automatic step(logic r, logic m, string tag);
    @(negedge clk);
    rst = r;
    mode = m;
    mdl = r ? 3'd0 : ref_next(mdl, m);
    expq.push_back(mdl);
    tagq.push_back(tag);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        logic [2:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, q, e);
      end
    end
  end

  initial begin
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    // full stride loop
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R7");
    // full mixed loop
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b0, "R7");
    // every value with each mode
    for (int v = 0; v < 8; v++) begin
      for (int m = 0; m < 2; m++) begin
        logic [2:0] vv;
        logic       mm;
        logic       b2;
        logic       b0;
        vv = 3'(v);
        mm = m[0];
        step(1'b1, 1'b0, "R1");
        while (mdl != vv) step(1'b0, 1'b1, "R2");
        step(1'b0, mm, "R4");
        @(posedge clk);
        #3;
        b2 = (!mm && !vv[0] && vv[2]) || (mm && vv[1] && !vv[2]) ||
             (!mm && vv[0] && !vv[2]) || (mm && !vv[1] && vv[2]);
        b0 = (!mm && !vv[0]) || (!vv[0] && vv[1] && vv[2]) ||
             (mm && vv[0] && !vv[2]) || (mm && vv[0] && !vv[1]);
        check("R5", {2'b00, q[2]}, {2'b00, b2});
        check("R6", {2'b00, q[0]}, {2'b00, b0});
        check("R7", {2'b00, q != vv}, 3'd1);
      end
    end
    // switch mode every cycle
    step(1'b1, 1'b1, "R1");
    for (int i = 0; i < 20; i++) step(1'b0, i[0], "R4");
    // irregular switching
    for (int i = 0; i < 12; i++) step(1'b0, (i % 3) == 0, "R4");
    // reset mid-run with mode high
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, "R3");
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: q=%0d expected=finish", q);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule